// File: doc/BRIEF.md
# Four-Channel Legacy DMA Controller

This block moves single data items between I/O devices and memory on behalf of four request lines. Software programs it through a narrow 8-bit register port: each channel has a 16-bit current address and a 16-bit remaining count. Both are reached one byte at a time through a shared byte pointer that alternates between the low and the high byte. A mode byte per channel picks the transfer direction, single or auto-initialize operation, or cascade. A single-mask byte enables or disables one channel at a time. A separate write port loads a per-channel page value that forms the upper address bits.

When an unmasked channel requests service, the controller asks the system for the bus with a hold request. After hold-acknowledge it grants the highest-priority pending channel, with channel 0 first. A normal channel then gets one transfer cycle. In that cycle the controller drives the full memory address, a read or write strobe and the channel acknowledge. It then steps the address up and the count down. When the count passes through zero it raises a one-cycle terminal-count pulse and sets a status bit. It then either masks the channel or reloads it from its base copies. A cascade channel drives no address and no strobe. It only hands the acknowledge to an external master for as long as that master keeps requesting.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset all four channels are masked, the byte pointer selects the low byte, and every mode byte is zero; requests then raise neither holdReq nor any dack.
- R2: A write of any value to offset 12 sets the byte pointer to the low byte. Every read or write at offsets 0 to 7 toggles the pointer, and one pointer is shared by all address and count registers.
- R3: Offset 2*c holds the address of channel c and offset 2*c+1 holds its count. A write loads both the base and the current copy, and a read returns the current copy.
- R4: A write to offset 10 selects a channel with bits [1:0]; bit 2 set masks it and bit 2 clear unmasks it. Requests from a masked channel are ignored.
- R5: A write to offset 11 selects a channel with bits [1:0]. Bits [3:2] = 01 selects a device-to-memory transfer with memWr, and 10 selects a memory-to-device transfer with memRd. Bit 4 set selects auto-initialize, and bits [7:6] = 11 selects cascade.
- R6: holdReq rises the cycle after an unmasked request appears. A dack is given only once holdAck is high, to the lowest-numbered pending unmasked channel.
- R7: During a transfer cycle memAddr equals {page, current address}, exactly one strobe is high with the channel's dack, and afterwards the address is one higher and the count one lower.
- R8: A count programmed as N-1 gives N transfers. tcPulse is high for one cycle on the last of them, the count then reads 0xFFFF, and a single-mode channel becomes masked.
- R9: An auto-initialize channel reloads its base address and base count at terminal count and stays unmasked.
- R10: A read at offset 8 returns the per-channel terminal-count bits in [3:0], which are set at terminal count and cleared by that read.
- R11: The 16-bit address wraps from 0xFFFF to 0x0000 with no carry into the page bits.
- R12: A cascade channel keeps dack and holdReq high while its request stays high and drops them the cycle after the request falls. It drives no strobe and leaves its address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | Register write strobe |
| ioRd | input | 1 | Register read strobe (reads have side effects) |
| ioOfs | input | 4 | Register offset |
| ioWData | input | 8 | Register write data |
| ioRData | output | 8 | Register read data for ioOfs |
| pageWr | input | 1 | Page register write strobe |
| pageCh | input | 2 | Channel whose page is written |
| pageData | input | PAGE_W | Page value |
| dreq | input | 4 | Channel requests |
| dack | output | 4 | Channel acknowledges |
| holdReq | output | 1 | Bus request to the system |
| holdAck | input | 1 | Bus grant from the system |
| memAddr | output | PAGE_W+16 | Memory address during a transfer |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| tcPulse | output | 1 | Terminal count on the last transfer |

## Verification
The bench builds the block with the default PAGE_W of 8, which gives a 24-bit memory address. At this width each page value stays visible next to the 16-bit counter, so the step from 0x07FFFF to 0x070000 shows directly that no carry enters the page. With the small counts the bench programs, terminal count, the 0xFFFF readback, auto-reload, priority between two pending channels and a cascade hand-off all come up within a few dozen cycles.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int CH_N   = 4;
  localparam int CH_W   = $clog2(CH_N);
  localparam int ADDR_W = 16;

  localparam logic [3:0] OFS_STAT  = 4'd8;
  localparam logic [3:0] OFS_MASK  = 4'd10;
  localparam logic [3:0] OFS_MODE  = 4'd11;
  localparam logic [3:0] OFS_FFCLR = 4'd12;

  localparam logic [1:0] DIR_TO_MEM   = 2'b01;
  localparam logic [1:0] DIR_FROM_MEM = 2'b10;
  localparam logic [1:0] KIND_CASC    = 2'b11;

  typedef struct packed {
    logic [1:0] kind;
    logic       autoInit;
    logic [1:0] dir;
  } chMode_t;

  typedef struct packed {
    logic            xfer;
    logic [CH_W-1:0] ch;
  } dmaStrobe_t;
endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ioWr,
  input  logic                     ioRd,
  input  logic [3:0]               ioOfs,
  input  logic [7:0]               ioWData,
  output logic [7:0]               ioRData,
  input  logic                     pageWr,
  input  logic [CH_W-1:0]          pageCh,
  input  logic [PAGE_W-1:0]        pageData,
  input  dmaStrobe_t               stb,
  output logic [CH_N-1:0]          chMask,
  output logic [CH_N-1:0]          chCasc,
  output logic [PAGE_W+ADDR_W-1:0] memAddr,
  output logic                     memRd,
  output logic                     memWr,
  output logic                     tcPulse
);
  logic [ADDR_W-1:0] baseAddr [CH_N];
  logic [ADDR_W-1:0] curAddr  [CH_N];
  logic [ADDR_W-1:0] baseCnt  [CH_N];
  logic [ADDR_W-1:0] curCnt   [CH_N];
  logic [PAGE_W-1:0] page     [CH_N];
  chMode_t           mode     [CH_N];
  logic [CH_N-1:0]   mask;
  logic [CH_N-1:0]   tcStat;
  logic              bytePtr;

  logic              regAcc;
  logic [CH_W-1:0]   regCh;
  logic              isCnt;
  logic              tcNow;
  logic [ADDR_W-1:0] rdSel;

  assign regAcc = (ioWr || ioRd) && !ioOfs[3];
  assign regCh  = ioOfs[CH_W:1];
  assign isCnt  = ioOfs[0];
  assign tcNow  = stb.xfer && (curCnt[stb.ch] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CH_N; i++) begin
        baseAddr[i] <= '0;
        curAddr[i]  <= '0;
        baseCnt[i]  <= '0;
        curCnt[i]   <= '0;
        page[i]     <= '0;
        mode[i]     <= '0;
      end
      mask    <= '1;
      tcStat  <= '0;
      bytePtr <= 1'b0;
    end else begin
      if (stb.xfer) begin
        if (tcNow && mode[stb.ch].autoInit) begin
          curAddr[stb.ch] <= baseAddr[stb.ch];
          curCnt[stb.ch]  <= baseCnt[stb.ch];
        end else begin
          curAddr[stb.ch] <= curAddr[stb.ch] + 1'b1;
          curCnt[stb.ch]  <= curCnt[stb.ch] - 1'b1;
        end
        if (tcNow && !mode[stb.ch].autoInit) mask[stb.ch] <= 1'b1;
      end
      if (ioRd && ioOfs == OFS_STAT) tcStat <= '0;
      if (tcNow) tcStat[stb.ch] <= 1'b1;
      if (regAcc) bytePtr <= ~bytePtr;
      if (pageWr) page[pageCh] <= pageData;
      if (ioWr) begin
        if (!ioOfs[3]) begin
          if (isCnt) begin
            if (bytePtr) begin
              baseCnt[regCh][15:8] <= ioWData;
              curCnt[regCh][15:8]  <= ioWData;
            end else begin
              baseCnt[regCh][7:0] <= ioWData;
              curCnt[regCh][7:0]  <= ioWData;
            end
          end else begin
            if (bytePtr) begin
              baseAddr[regCh][15:8] <= ioWData;
              curAddr[regCh][15:8]  <= ioWData;
            end else begin
              baseAddr[regCh][7:0] <= ioWData;
              curAddr[regCh][7:0]  <= ioWData;
            end
          end
        end else if (ioOfs == OFS_MASK) begin
          mask[ioWData[CH_W-1:0]] <= ioWData[2];
        end else if (ioOfs == OFS_MODE) begin
          mode[ioWData[CH_W-1:0]] <= '{kind: ioWData[7:6], autoInit: ioWData[4],
                                      dir: ioWData[3:2]};
        end else if (ioOfs == OFS_FFCLR) begin
          bytePtr <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    ioRData = '0;
    rdSel   = isCnt ? curCnt[regCh] : curAddr[regCh];
    if (!ioOfs[3]) ioRData = bytePtr ? rdSel[15:8] : rdSel[7:0];
    else if (ioOfs == OFS_STAT) ioRData = {{(8-CH_N){1'b0}}, tcStat};
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_casc
    assign chCasc[g] = (mode[g].kind == KIND_CASC);
  end

  assign chMask  = mask;
  assign memAddr = {page[stb.ch], curAddr[stb.ch]};
  assign memRd   = stb.xfer && (mode[stb.ch].dir == DIR_FROM_MEM);
  assign memWr   = stb.xfer && (mode[stb.ch].dir == DIR_TO_MEM);
  assign tcPulse = tcNow;
endmodule

// File: rtl/dma4_ctl.sv
module dma4_ctl
  import dma4_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [CH_N-1:0] dreq,
  input  logic            holdAck,
  input  logic [CH_N-1:0] chMask,
  input  logic [CH_N-1:0] chCasc,
  output logic            holdReq,
  output logic [CH_N-1:0] dack,
  output dmaStrobe_t      stb
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_CASC} ctlState_t;

  ctlState_t       state;
  logic [CH_W-1:0] selCh;
  logic [CH_W-1:0] prio;
  logic [CH_N-1:0] pend;

  assign pend = dreq & ~chMask;

  always_comb begin
    prio = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (pend[i]) prio = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      selCh <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (|pend) state <= S_WAIT;
        S_WAIT: begin
          if (!(|pend)) state <= S_IDLE;
          else if (holdAck) begin
            selCh <= prio;
            state <= chCasc[prio] ? S_CASC : S_XFER;
          end
        end
        S_XFER: state <= S_IDLE;
        S_CASC: if (!pend[selCh]) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dack = '0;
    if (state == S_XFER || state == S_CASC) dack[selCh] = 1'b1;
  end

  assign holdReq  = (state != S_IDLE);
  assign stb.xfer = (state == S_XFER);
  assign stb.ch   = selCh;
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ioWr,
  input  logic                     ioRd,
  input  logic [3:0]               ioOfs,
  input  logic [7:0]               ioWData,
  output logic [7:0]               ioRData,
  input  logic                     pageWr,
  input  logic [1:0]               pageCh,
  input  logic [PAGE_W-1:0]        pageData,
  input  logic [3:0]               dreq,
  output logic [3:0]               dack,
  output logic                     holdReq,
  input  logic                     holdAck,
  output logic [PAGE_W+15:0]       memAddr,
  output logic                     memRd,
  output logic                     memWr,
  output logic                     tcPulse
);
  dmaStrobe_t      stb;
  logic [CH_N-1:0] chMask;
  logic [CH_N-1:0] chCasc;

  dma4_ctl ctl_i (
    .clk(clk), .rstN(rstN), .dreq(dreq), .holdAck(holdAck),
    .chMask(chMask), .chCasc(chCasc), .holdReq(holdReq), .dack(dack), .stb(stb)
  );

  dma4_regs #(.PAGE_W(PAGE_W)) regs_i (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioOfs(ioOfs),
    .ioWData(ioWData), .ioRData(ioRData), .pageWr(pageWr), .pageCh(pageCh),
    .pageData(pageData), .stb(stb), .chMask(chMask), .chCasc(chCasc),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .tcPulse(tcPulse)
  );
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] dack,
  input logic       holdReq,
  input logic       holdAck,
  input logic       memRd,
  input logic       memWr,
  input logic       tcPulse
);
  a_r6_dack_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dack));
  a_r6_dack_under_hold: assert property (@(posedge clk) disable iff (!rstN)
    (|dack) |-> holdReq);
  a_r6_grant_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|dack) |-> ($past(holdReq) && $past(holdAck)));
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  a_r7_strobe_with_dack: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> (|dack));
  a_r8_tc_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |=> !tcPulse);
  a_r8_tc_with_dack: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> (|dack));
endmodule

bind dma4_ctrl dma4_ctrl_chk chk_i (.*);

// File: tb/dma4_ctrl_tb.sv
module dma4_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWr = 1'b0, ioRd = 1'b0;
  logic [3:0]  ioOfs = '0;
  logic [7:0]  ioWData = '0;
  logic [7:0]  ioRData;
  logic        pageWr = 1'b0;
  logic [1:0]  pageCh = '0;
  logic [7:0]  pageData = '0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic        holdReq;
  logic        holdAck = 1'b1;
  logic [23:0] memAddr;
  logic        memRd, memWr, tcPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma4_ctrl dut_i (.*);

  // op(1: read-compare) ofs data expect
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd12, 8'h00, 8'h00},
    {1'b0, 4'd0,  8'h34, 8'h00}, {1'b0, 4'd0, 8'h12, 8'h00},
    {1'b0, 4'd1,  8'h02, 8'h00}, {1'b0, 4'd1, 8'h00, 8'h00},
    {1'b1, 4'd0,  8'h00, 8'h34}, {1'b1, 4'd0, 8'h00, 8'h12},
    {1'b1, 4'd1,  8'h00, 8'h02}, {1'b1, 4'd1, 8'h00, 8'h00},
    {1'b0, 4'd2,  8'hFF, 8'h00}, {1'b0, 4'd12, 8'h00, 8'h00},
    {1'b1, 4'd2,  8'h00, 8'hFF}, {1'b1, 4'd2, 8'h00, 8'h00},
    {1'b0, 4'd12, 8'h00, 8'h00}, {1'b0, 4'd0, 8'hAA, 8'h00},
    {1'b1, 4'd1,  8'h00, 8'h00}, {1'b0, 4'd0, 8'h34, 8'h00},
    {1'b0, 4'd12, 8'h00, 8'h00}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrIo(logic [3:0] ofs, logic [7:0] d);
    @(negedge clk); ioWr = 1'b1; ioOfs = ofs; ioWData = d;
    @(negedge clk); ioWr = 1'b0;
  endtask

  task automatic rdIo(logic [3:0] ofs, output logic [7:0] d);
    @(negedge clk); ioRd = 1'b1; ioOfs = ofs;
    #1 d = ioRData;
    @(negedge clk); ioRd = 1'b0;
  endtask

  task automatic rdChk(string req, logic [3:0] ofs, logic [7:0] exp);
    logic [7:0] d;
    rdIo(ofs, d);
    check(req, d, exp);
  endtask

  task automatic wrPage(logic [1:0] ch, logic [7:0] p);
    @(negedge clk); pageWr = 1'b1; pageCh = ch; pageData = p;
    @(negedge clk); pageWr = 1'b0;
  endtask

  task automatic waitDack();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dack != 0) break;
    end
  endtask

  task automatic xfer(string req, int ch, logic [23:0] expAddr, logic expRd,
                      logic expWr, logic expTc);
    @(negedge clk); dreq[ch] = 1'b1;
    waitDack();
    check({req, " dack"}, dack, 4'(1 << ch));
    check({req, " memAddr"}, memAddr, expAddr);
    check({req, " memRd"}, memRd, expRd);
    check({req, " memWr"}, memWr, expWr);
    check({req, " tcPulse"}, tcPulse, expTc);
    dreq[ch] = 1'b0;
  endtask

  task automatic noService(string req, int ch);
    @(negedge clk); dreq[ch] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(req, {holdReq, dack}, 5'b0);
    end
    dreq[ch] = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs and all channels masked after reset
    check("R1 hold", holdReq, 1'b0);
    check("R1 dack", dack, 4'h0);
    @(negedge clk); dreq = 4'hF;
    repeat (4) begin @(negedge clk); check("R1 masked", {holdReq, dack}, 5'b0); end
    dreq = 4'h0;
    rdChk("R10 status reset", 4'd8, 8'h00);

    // R2, R3: register access through the byte pointer
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][20]) rdChk("R2/R3 vector", VEC[v][19:16], VEC[v][7:0]);
      else wrIo(VEC[v][19:16], VEC[v][15:8]);
    end

    // R5, R7, R8: ch0 single, to memory, three transfers
    wrPage(2'd0, 8'h5A);
    wrIo(4'd11, 8'h04);
    wrIo(4'd10, 8'h00);  // R4 unmask
    xfer("R7 x1", 0, 24'h5A1234, 1'b0, 1'b1, 1'b0);
    xfer("R7 x2", 0, 24'h5A1235, 1'b0, 1'b1, 1'b0);
    xfer("R8 last", 0, 24'h5A1236, 1'b0, 1'b1, 1'b1);
    wrIo(4'd12, 8'h00);
    rdChk("R8 count lo", 4'd1, 8'hFF);
    rdChk("R8 count hi", 4'd1, 8'hFF);
    rdChk("R7 addr lo", 4'd0, 8'h37);
    rdChk("R7 addr hi", 4'd0, 8'h12);
    noService("R8 single masks", 0);
    rdChk("R10 status set", 4'd8, 8'h01);
    rdChk("R10 status cleared", 4'd8, 8'h00);

    // R6, R9: ch1 auto-init from memory, hold handshake
    wrIo(4'd12, 8'h00);
    wrIo(4'd2, 8'h10); wrIo(4'd2, 8'h00);
    wrIo(4'd3, 8'h00); wrIo(4'd3, 8'h00);
    wrIo(4'd11, 8'h19);
    wrPage(2'd1, 8'h03);
    wrIo(4'd10, 8'h01);
    holdAck = 1'b0;
    @(negedge clk); dreq[1] = 1'b1;
    @(negedge clk);
    check("R6 hold raised", holdReq, 1'b1);
    repeat (3) begin @(negedge clk); check("R6 no dack before ack", dack, 4'h0); end
    holdAck = 1'b1;
    @(negedge clk);
    check("R6 dack after ack", dack, 4'b0010);
    check("R5 memRd dir", {memRd, memWr}, 2'b10);
    check("R9 addr", memAddr, 24'h030010);
    check("R9 tc", tcPulse, 1'b1);
    dreq[1] = 1'b0;
    wrIo(4'd12, 8'h00);
    rdChk("R9 reload addr lo", 4'd2, 8'h10);
    rdChk("R9 reload addr hi", 4'd2, 8'h00);
    xfer("R9 still unmasked", 1, 24'h030010, 1'b1, 1'b0, 1'b1);

    // R6 priority, R11 wrap: ch2 at 0xFFFF, count 1
    wrIo(4'd12, 8'h00);
    wrIo(4'd4, 8'hFF); wrIo(4'd4, 8'hFF);
    wrIo(4'd5, 8'h01); wrIo(4'd5, 8'h00);
    wrIo(4'd11, 8'h06);
    wrPage(2'd2, 8'h07);
    wrIo(4'd10, 8'h02);
    @(negedge clk); dreq = 4'b0110;
    waitDack();
    check("R6 priority ch1 first", dack, 4'b0010);
    dreq[1] = 1'b0;
    waitDack();
    if (dack == 4'b0010) waitDack();
    check("R6 then ch2", dack, 4'b0100);
    check("R11 addr before wrap", memAddr, 24'h07FFFF);
    dreq[2] = 1'b0;
    xfer("R11 wrap no carry", 2, 24'h070000, 1'b0, 1'b1, 1'b1);

    rdChk("R10 status ch1 ch2", 4'd8, 8'h06);

    // R12: cascade on ch3
    wrIo(4'd11, 8'hC3);
    wrIo(4'd10, 8'h03);
    @(negedge clk); dreq[3] = 1'b1;
    waitDack();
    repeat (3) begin
      check("R12 dack held", {holdReq, dack}, 5'b11000);
      check("R12 no strobe", {memRd, memWr, tcPulse}, 3'b000);
      @(negedge clk);
    end
    dreq[3] = 1'b0;
    @(negedge clk);
    check("R12 release", {holdReq, dack}, 5'b0);
    wrIo(4'd12, 8'h00);
    rdChk("R12 addr untouched", 4'd6, 8'h00);

    // R4: mask with bit 2
    wrIo(4'd10, 8'h05);
    noService("R4 masked ignored", 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule